// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache Controller

This controller serves the data loads and stores of a 32-bit in-order pipeline. Lines are one 32-bit word each, indexed directly by the physical address. The tag, data and valid storage sits in an external RAM with an asynchronous read port and a synchronous write port. The controller drives that RAM's line index, compares the returned tag against the full upper twenty address bits, and answers a load hit in the same cycle it is presented.

Stores are written through. Each accepted store writes its word into the line it maps to and is queued in a small FIFO store buffer, which drains to main memory in arrival order. A load that misses freezes the pipeline by holding `cpu_req_ready` low. The controller then waits for the store buffer to empty, issues one word read, refills the line and completes the load when the data returns. After reset the controller first walks every line and clears its valid bit. No request is accepted until that walk has finished.

Back-pressure rules: a CPU request is accepted on a cycle with `cpu_req_valid && cpu_req_ready`. The CPU holds the request unchanged until then. A memory request is accepted on `mem_req_valid && mem_req_ready`. The controller keeps address, data and direction stable while it waits. `mem_rsp_valid` is a one-cycle pulse with no ready, and memory returns exactly one pulse per accepted read.

Top module: `wt_dcache`

## Requirements
- R1: After reset, the controller writes valid = 0 to every one of the 2^IDX_W lines, one per cycle. It holds `cpu_req_ready` low for about 2^IDX_W cycles. A load that follows misses, even if the RAM held stale valid lines.
- R2: A load whose line is valid and whose stored tag matches is accepted in the cycle it is presented. In that same cycle `cpu_rsp_valid` is 1 and `cpu_rsp_rdata` is the stored word. No memory read is issued for it.
- R3: A load that misses keeps `cpu_req_ready` low and issues one read (`mem_req_we` = 0) to the word address, with bits 1:0 equal to 0. It completes in the cycle `mem_rsp_valid` is high, returning `mem_rsp_data`. In that cycle it also writes the tag, the data and valid = 1 into the line.
- R4: The line index is address bits IDX_W+1:2. The tag compared and stored is always bits 31:12, whatever IDX_W is. Bits 1:0 are ignored.
- R5: A store is accepted in the cycle it is presented when the buffer is not full. It writes its tag, its data and valid = 1 into the line, whether the line hit or missed, and is queued for memory.
- R6: Queued stores go to memory as writes (`mem_req_we` = 1) in acceptance order. One entry leaves per accepted memory request.
- R7: When the buffer holds SB_DEPTH entries, a store waits with `cpu_req_ready` low until an entry drains.
- R8: A miss read is issued only when the store buffer is empty, so a load never sees a word older than a store accepted before it.
- R9: While a miss read is outstanding, no memory request is raised and no CPU request is accepted.
- R10: A memory request that is not accepted stays raised, with unchanged address, data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | CPU request accepted this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Physical byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (same cycle as acceptance) |
| cpu_rsp_rdata | output | 32 | Load data |
| ram_idx | output | IDX_W | Line index to tag/data RAM |
| ram_we | output | 1 | RAM line write |
| ram_wtag | output | 20 | Tag to write |
| ram_wdata | output | 32 | Data word to write |
| ram_wvalid | output | 1 | Valid bit to write |
| ram_rtag | input | 20 | Tag read at `ram_idx` |
| ram_rdata | input | 32 | Data read at `ram_idx` |
| ram_rvalid | input | 1 | Valid bit read at `ram_idx` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 32 | Read data |

## Verification
The properties assume a CPU that holds its request unchanged until accepted. They also assume a memory that returns exactly one response pulse per accepted read and never pulses otherwise. The bench's CPU task keeps each request stable across stall cycles. Its memory model answers each accepted read once, after a fixed delay. The model also raises or drops `mem_req_ready` only between edges, so back-pressure can be applied while these rules still hold.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 2;
  localparam int TAG_W  = 20;
  localparam int WADDR_W = ADDR_W - OFF_W;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [WORD_W-1:0]  data;
  } sb_entry_t;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/wtc_sbuf.sv
module wtc_sbuf
  import wtc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  sb_entry_t        din,
  input  logic             pop,
  output sb_entry_t        head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  sb_entry_t        slot [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && wr_ptr == PTR_W'(i)) slot[i] <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = slot[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wtc_tagcmp.sv
module wtc_tagcmp
  import wtc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  rtag,
  input  logic              rvalid,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag,
  output logic              hit
);
  logic [OFF_W-1:0] unused_off;

  assign unused_off = addr[OFF_W-1:0];
  assign idx = addr[IDX_W+OFF_W-1:OFF_W];
  assign tag = addr[ADDR_W-1:ADDR_W-TAG_W];
  assign hit = rvalid && (rtag == tag);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic             hit,
  input  logic             sb_empty,
  input  logic             sb_full,
  input  logic             rd_acc,
  input  logic             rsp_in,
  output ctl_state_t       state,
  output logic [IDX_W-1:0] clr_idx,
  output logic             clr_we,
  output logic             fill_we,
  output logic             sb_push,
  output logic             rd_req,
  output logic             cpu_ready,
  output logic             cpu_rsp
);
  localparam logic [IDX_W-1:0] LAST = '1;

  ctl_state_t nxt;

  always_comb begin
    nxt       = state;
    clr_we    = 1'b0;
    fill_we   = 1'b0;
    sb_push   = 1'b0;
    rd_req    = 1'b0;
    cpu_ready = 1'b0;
    cpu_rsp   = 1'b0;
    case (state)
      ST_CLEAR: begin
        clr_we = 1'b1;
        if (clr_idx == LAST) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (cpu_valid) begin
          if (cpu_we) begin
            cpu_ready = !sb_full;
            sb_push   = !sb_full;
          end else if (hit) begin
            cpu_ready = 1'b1;
            cpu_rsp   = 1'b1;
          end else begin
            nxt = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        rd_req = sb_empty;
        if (rd_acc) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_in) begin
          fill_we   = 1'b1;
          cpu_ready = 1'b1;
          cpu_rsp   = 1'b1;
          nxt       = ST_RUN;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CLEAR;
      clr_idx <= '0;
    end else begin
      state <= nxt;
      if (state == ST_CLEAR) clr_idx <= clr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtc_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int SB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [31:0]       cpu_req_addr,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rsp_rdata,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              ram_we,
  output logic [19:0]       ram_wtag,
  output logic [31:0]       ram_wdata,
  output logic              ram_wvalid,
  input  logic [19:0]       ram_rtag,
  input  logic [31:0]       ram_rdata,
  input  logic              ram_rvalid,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int CNT_W = $clog2(SB_DEPTH + 1);

  ctl_state_t       state;
  logic [IDX_W-1:0] cpu_idx, clr_idx;
  logic [TAG_W-1:0] cpu_tag;
  logic             hit, clr_we, fill_we, sb_push, rd_req;
  logic             sb_empty, sb_full, sb_pop, rd_acc;
  logic [CNT_W-1:0] sb_cnt;
  sb_entry_t        sb_head, sb_in;

  wtc_tagcmp #(.IDX_W(IDX_W)) u_cmp (
    .addr(cpu_req_addr), .rtag(ram_rtag), .rvalid(ram_rvalid),
    .idx(cpu_idx), .tag(cpu_tag), .hit(hit)
  );

  wtc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_req_valid), .cpu_we(cpu_req_we), .hit(hit),
    .sb_empty(sb_empty), .sb_full(sb_full), .rd_acc(rd_acc), .rsp_in(mem_rsp_valid),
    .state(state), .clr_idx(clr_idx), .clr_we(clr_we), .fill_we(fill_we),
    .sb_push(sb_push), .rd_req(rd_req), .cpu_ready(cpu_req_ready), .cpu_rsp(cpu_rsp_valid)
  );

  assign sb_in.waddr = cpu_req_addr[ADDR_W-1:OFF_W];
  assign sb_in.data  = cpu_req_wdata;

  wtc_sbuf #(.DEPTH(SB_DEPTH), .CNT_W(CNT_W)) u_sbuf (
    .clk(clk), .rst_n(rst_n), .push(sb_push), .din(sb_in), .pop(sb_pop),
    .head(sb_head), .empty(sb_empty), .full(sb_full), .count(sb_cnt)
  );

  // tag/data RAM side
  assign ram_idx    = clr_we ? clr_idx : cpu_idx;
  assign ram_we     = clr_we | fill_we | sb_push;
  assign ram_wvalid = !clr_we;
  assign ram_wtag   = clr_we ? '0 : cpu_tag;
  assign ram_wdata  = clr_we ? '0 : (fill_we ? mem_rsp_data : cpu_req_wdata);

  // memory side: buffered writes first, the miss read only once they are gone
  assign mem_req_we    = !sb_empty;
  assign mem_req_valid = !sb_empty || rd_req;
  assign mem_req_addr  = sb_empty ? {cpu_req_addr[ADDR_W-1:OFF_W], 2'b00}
                                  : {sb_head.waddr, 2'b00};
  assign mem_req_wdata = sb_head.data;
  assign sb_pop        = !sb_empty && mem_req_ready;
  assign rd_acc        = rd_req && mem_req_ready;

  assign cpu_rsp_rdata = (state == ST_WAIT) ? mem_rsp_data : ram_rdata;
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int SB_DEPTH = 4,
  parameter int CNT_W    = $clog2(SB_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic             cpu_req_we,
  input logic             cpu_rsp_valid,
  input logic             ram_we,
  input logic             ram_wvalid,
  input logic [31:0]      ram_wdata,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [31:0]      mem_req_addr,
  input logic [31:0]      mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic [31:0]      mem_rsp_data,
  input logic [CNT_W-1:0] sb_cnt
);
  logic rd_out;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_out <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_out <= 1'b1;
    else if (mem_rsp_valid) rd_out <= 1'b0;
  end

  p_clear_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !ram_wvalid |-> !cpu_req_ready);

  p_rsp_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_req_valid && cpu_req_ready && !cpu_req_we);

  p_refill_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out && mem_rsp_valid |-> ram_we && ram_wvalid && ram_wdata == mem_rsp_data
                                && cpu_rsp_valid);

  p_read_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_addr[1:0] == 2'b00);

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_we && sb_cnt == CNT_W'(SB_DEPTH) |-> !cpu_req_ready);

  p_read_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> sb_cnt == '0);

  p_no_hit_under_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out && !mem_rsp_valid |-> !mem_req_valid && !cpu_req_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && (!mem_req_we || $stable(mem_req_wdata)));
endmodule

bind wt_dcache wt_dcache_chk #(.SB_DEPTH(SB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
  .cpu_rsp_valid(cpu_rsp_valid),
  .ram_we(ram_we), .ram_wvalid(ram_wvalid), .ram_wdata(ram_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
  .sb_cnt(sb_cnt)
);

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
  localparam int IDX_W = 10;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0]      cpu_req_addr = '0, cpu_req_wdata = '0;
  logic             cpu_req_ready, cpu_rsp_valid;
  logic [31:0]      cpu_rsp_rdata;
  logic [IDX_W-1:0] ram_idx;
  logic             ram_we, ram_wvalid, ram_rvalid;
  logic [19:0]      ram_wtag, ram_rtag;
  logic [31:0]      ram_wdata, ram_rdata;
  logic             mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0]      mem_req_addr, mem_req_wdata;
  logic             mem_rsp_valid = 1'b0;
  logic [31:0]      mem_rsp_data = '0;
  logic             mem_block = 1'b0;

  wt_dcache #(.IDX_W(IDX_W), .SB_DEPTH(4)) u_wt_dcache (.*);

  // external tag/data RAM: async read, sync write; preloaded with stale valid lines
  logic [52:0] ram [LINES];
  initial for (int i = 0; i < LINES; i++) ram[i] = {1'b1, 20'h00000, 32'(i * 3 + 7)};
  always @(posedge clk) if (ram_we) ram[ram_idx] <= {ram_wvalid, ram_wtag, ram_wdata};
  assign {ram_rvalid, ram_rtag, ram_rdata} = ram[ram_idx];

  // main memory model
  function automatic logic [31:0] dflt(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction
  logic [31:0] mm [logic [29:0]];
  function automatic logic [31:0] mm_rd(input logic [31:0] a);
    return mm.exists(a[31:2]) ? mm[a[31:2]] : dflt(a);
  endfunction

  logic        log_we [$];
  logic [31:0] log_addr [$];
  int          pend = 0, reads = 0, r9_viol = 0, r10_viol = 0;
  logic [31:0] rsp_addr = '0, prev_addr = '0;
  logic        prev_stall = 1'b0;

  assign mem_req_ready = !mem_block;

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) r10_viol++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && (pend != 0 || mem_rsp_valid)) r9_viol++;
      if (mem_req_valid && mem_req_ready) begin
        log_we.push_back(mem_req_we);
        log_addr.push_back(mem_req_addr);
        if (mem_req_we) mm[mem_req_addr[31:2]] = mem_req_wdata;
        else begin pend = 3; rsp_addr = mem_req_addr; reads++; end
      end else if (pend != 0) begin
        pend--;
      end
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mm_rd(rsp_addr);
        pend = 0;
      end else begin
        mem_rsp_valid <= 1'b0;
      end
    end
  end

  // bookkeeping
  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [31:0] a, d,
                            output logic [31:0] rd, output logic rsp, output int waits);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    waits = 0; rd = '0; rsp = 1'b0;
    forever begin
      #4;
      if (cpu_req_ready) begin
        rd = cpu_rsp_rdata; rsp = cpu_rsp_valid;
        @(posedge clk);
        break;
      end
      waits++;
      @(posedge clk);
      if (waits > 5000) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  // reference line state
  logic        rv [LINES];
  logic [19:0] rt [LINES];
  logic [31:0] rm [logic [29:0]];
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return rm.exists(a[31:2]) ? rm[a[31:2]] : dflt(a);
  endfunction

  // stimulus table: {we, addr, wdata}
  localparam int NV = 10;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h0000_0010, 32'h0},          // R1: stale line must miss
    {1'b0, 32'h0000_1004, 32'h0},          // R3 miss
    {1'b0, 32'h0000_1004, 32'h0},          // R2 hit
    {1'b1, 32'h0000_1004, 32'h1111_2222},  // R5 store hit
    {1'b0, 32'h0000_1004, 32'h0},          // R2 hit new data
    {1'b0, 32'h0000_2004, 32'h0},          // R3 conflict miss
    {1'b0, 32'h0000_1004, 32'h0},          // R3/R6 refetch written-through data
    {1'b0, 32'h0000_1006, 32'h0},          // R4 offset ignored
    {1'b1, 32'h0040_0008, 32'hDEAD_0001},  // R5 store miss allocates
    {1'b0, 32'h0080_0008, 32'h0}           // R4 tag bit 23 differs
  };

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        rsp;
    int          w, base, r0;
    for (int i = 0; i < LINES; i++) begin rv[i] = 1'b0; rt[i] = '0; end

    repeat (3) @(negedge clk);
    chk(cpu_req_ready == 1'b0, "R1 ready low in reset/clear", {31'd0, cpu_req_ready}, 32'd0);
    rst_n = 1'b1;

    // R1: clear walk stalls the first request
    cpu_access(1'b1, 32'h0000_0FFC, 32'hC0FF_EE00, rd, rsp, w);
    chk(w >= LINES - 2 && w <= LINES, "R1 clear walk length", w, LINES - 1);
    rv[1023] = 1'b1; rt[1023] = 20'h0; rm[30'h3FF] = 32'hC0FF_EE00;

    // table
    for (int k = 0; k < NV; k++) begin
      logic        we;
      logic [31:0] a, d;
      logic [IDX_W-1:0] ix;
      bit          exp_hit;
      {we, a, d} = VEC[k];
      ix = a[IDX_W+1:2];
      exp_hit = rv[ix] && rt[ix] == a[31:12];
      r0 = reads;
      cpu_access(we, a, d, rd, rsp, w);
      if (we) begin
        chk(w == 0, "R5 store accepted at once", w, 0);
        rm[a[31:2]] = d;
      end else begin
        chk(rsp === 1'b1, "R2/R3 load response", {31'd0, rsp}, 32'd1);
        chk(rd == ref_rd(a), exp_hit ? "R2 hit data" : "R3 miss data", rd, ref_rd(a));
        if (exp_hit) begin
          chk(w == 0 && reads == r0, "R2 hit in one cycle, no read", w, 0);
        end else begin
          chk(w > 0 && reads == r0 + 1, "R3 miss stalls with one read", reads - r0, 1);
          chk(log_addr[$] == {a[31:2], 2'b00} && !log_we[$], "R3 read address aligned",
              log_addr[$], {a[31:2], 2'b00});
        end
      end
      rv[ix] = 1'b1; rt[ix] = a[31:12];
    end

    // R7 + R6: fill the buffer while memory is blocked
    repeat (4) @(negedge clk);
    mem_block = 1'b1;
    base = log_we.size();
    for (int i = 0; i < 4; i++) begin
      cpu_access(1'b1, 32'h5000_0100 + 32'(4 * i), 32'hA0 + 32'(i), rd, rsp, w);
      chk(w == 0, "R5 store into non-full buffer", w, 0);
    end
    fork
      cpu_access(1'b1, 32'h5000_0110, 32'hA4, rd, rsp, w);
      begin repeat (8) @(negedge clk); mem_block = 1'b0; end
    join
    chk(w >= 7, "R7 full buffer stalls store", w, 7);
    repeat (12) @(negedge clk);
    chk(log_we.size() == base + 5, "R6 five writes drained", log_we.size() - base, 5);
    for (int i = 0; i < 5; i++)
      chk(log_we[base + i] && log_addr[base + i] == 32'h5000_0100 + 32'(4 * i),
          "R6 FIFO write order", log_addr[base + i], 32'h5000_0100 + 32'(4 * i));
    for (int i = 0; i < 5; i++) rm[30'(32'h1400_0040 + i)] = 32'hA0 + 32'(i);

    // R8: evicted store still in buffer must reach memory before the refetch
    base = log_we.size();
    mem_block = 1'b1;
    cpu_access(1'b1, 32'h6000_0040, 32'h1234_5678, rd, rsp, w);
    cpu_access(1'b1, 32'h7000_0040, 32'h8765_4321, rd, rsp, w);
    fork
      cpu_access(1'b0, 32'h6000_0040, 32'h0, rd, rsp, w);
      begin repeat (6) @(negedge clk); mem_block = 1'b0; end
    join
    chk(rd == 32'h1234_5678, "R8 load sees buffered store", rd, 32'h1234_5678);
    chk(log_we.size() == base + 3 && log_we[base] && log_we[base + 1] && !log_we[base + 2],
        "R8 read issued after drain", log_we.size() - base, 3);
    chk(log_addr[base + 2] == 32'h6000_0040, "R8 read address", log_addr[base + 2],
        32'h6000_0040);

    repeat (5) @(negedge clk);
    chk(r9_viol == 0, "R9 no request while read outstanding", r9_viol, 0);
    chk(r10_viol == 0, "R10 stalled request held", r10_viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule